// File: doc/BRIEF.md
# Table-Driven Fuzzifier with Adjacent-Pair Output

This block turns one crisp 8-bit sample into the compact fuzzy form used by a small controller. Membership shapes are never evaluated arithmetically; instead a writable table, addressed directly by the crisp value, gives for every possible input the number of the lower of the active fuzzy sets together with two membership degrees. The first degree is for that set and the second for its upper neighbour. Since at most two sets overlap anywhere on the input axis, this pair always holds every non-zero membership. A controller with four inputs places four of these blocks side by side and so hands eight non-zero degrees to its inference stage.

A lookup is requested by pulsing `in_valid` with the crisp value. One clock later the registered result appears with `out_valid`. Software or a calibration engine fills the table through a simple write port: one entry is written per enabled cycle. When nothing is requested, the output register keeps its contents.

Top module: `fzf_lut_fuzzifier`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0 and `out_index`, `out_deg_lo` and `out_deg_hi` are all 0.
- R2: `out_valid` after a rising clock edge equals `in_valid` sampled at that edge. The result therefore follows its request by exactly one cycle.
- R3: When `in_valid` is high, the next cycle presents on `out_index`, `out_deg_lo` and `out_deg_hi` the index, lower-set degree and upper-set degree stored at table address `in_crisp`.
- R4: When `wr_en` is high at a clock edge, the entry at `wr_addr` becomes {`wr_index`, `wr_deg_lo`, `wr_deg_hi`}. A lookup of that address in any later cycle returns the new contents.
- R5: A lookup made in the same cycle as a write to the same address returns the contents that the entry held before the write.
- R6: When the stored index is the highest set number (7, all ones), the set has no upper neighbour and `out_deg_hi` is presented as 0, whatever the table holds.
- R7: In a cycle after one where `in_valid` was low, `out_index`, `out_deg_lo` and `out_deg_hi` keep their previous values.
- R8: When `wr_en` is low, the values on `wr_addr` and on the write data inputs change no table entry.
- R9: A write changes only the entry at `wr_addr`. All other entries are left as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| in_valid | input | 1 | Lookup request |
| in_crisp | input | 8 | Crisp input value used as the table address |
| wr_en | input | 1 | Table write enable |
| wr_addr | input | 8 | Table entry to write |
| wr_index | input | 3 | Lower-set index to store |
| wr_deg_lo | input | 8 | Degree for the lower set to store |
| wr_deg_hi | input | 8 | Degree for the upper set to store |
| out_valid | output | 1 | Result valid, one cycle after the request |
| out_index | output | 3 | Lower active set index |
| out_deg_lo | output | 8 | Membership degree for set `out_index` |
| out_deg_hi | output | 8 | Membership degree for set `out_index`+1 |

## Verification
The assertions assume that `in_valid` and the write port carry defined levels once reset has been released. They make no assumption about the order in which the table is filled, because the checks on latency, hold and the top-set clip do not depend on what the table holds. The stimulus fills every address before the first lookup. After that, each input is driven at the falling clock edge, so every request and every write meets the next rising edge with settled values. The bench models the table as its own array and builds its expected results from that model and from the clip rule for the top set.

// File: rtl/fzf_pkg.sv
package fzf_pkg;

  // Width of the lower-set index and of one membership degree.
  localparam int unsigned FZF_IDX_W = 3;
  localparam int unsigned FZF_DEG_W = 8;

  // Number of fuzzy sets on one input axis and the number of the top set.
  localparam int unsigned FZF_NUM_SETS = 1 << FZF_IDX_W;
  localparam logic [FZF_IDX_W-1:0] FZF_TOP_SET = FZF_IDX_W'(FZF_NUM_SETS - 1);

  // One table word: lower active set and the degrees for it and its neighbour.
  typedef struct packed {
    logic [FZF_IDX_W-1:0] idx;
    logic [FZF_DEG_W-1:0] deg_lo;
    logic [FZF_DEG_W-1:0] deg_hi;
  } fzf_entry_t;

  localparam int unsigned FZF_ENTRY_W = $bits(fzf_entry_t);

endpackage

// File: rtl/fzf_table.sv
// Membership storage: one word per crisp value, with a synchronous write
// and an asynchronous read. A read in the write cycle sees the old word.
module fzf_table
  import fzf_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  fzf_entry_t        wr_entry,
  input  logic [ADDR_W-1:0] rd_addr,
  output fzf_entry_t        rd_entry
);

  localparam int unsigned DEPTH = 1 << ADDR_W;

  fzf_entry_t mem_q [DEPTH];

  // Storage array: written only when enabled, no reset on contents.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem_q[wr_addr] <= wr_entry;
    end
  end

  always_comb begin
    rd_entry = mem_q[rd_addr];
  end

endmodule

// File: rtl/fzf_clip.sv
// Removes the upper-neighbour degree when the lower set is the last one,
// because no set above it exists.
module fzf_clip
  import fzf_pkg::*;
#(
  parameter bit CLIP_TOP = 1'b1
) (
  input  fzf_entry_t raw_entry,
  output fzf_entry_t clean_entry
);

  generate
    if (CLIP_TOP) begin : g_clip
      always_comb begin
        clean_entry = raw_entry;
        if (raw_entry.idx == FZF_TOP_SET) begin
          clean_entry.deg_hi = '0;
        end
      end
    end else begin : g_pass
      always_comb begin
        clean_entry = raw_entry;
      end
    end
  endgenerate

endmodule

// File: rtl/fzf_out_reg.sv
// Output stage: valid flag tracks the request, data loads only on request.
module fzf_out_reg
  import fzf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  fzf_entry_t d_entry,
  output logic       q_valid,
  output fzf_entry_t q_entry
);

  logic       valid_d;
  fzf_entry_t entry_d;

  // Next-state logic with the clock enable spelled out.
  always_comb begin
    valid_d = load;
    entry_d = q_entry;
    if (load) begin
      entry_d = d_entry;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q_entry <= '0;
    end else begin
      q_valid <= valid_d;
      q_entry <= entry_d;
    end
  end

endmodule

// File: rtl/fzf_lut_fuzzifier.sv
module fzf_lut_fuzzifier
  import fzf_pkg::*;
#(
  parameter int unsigned CRISP_W  = 8,
  parameter bit          CLIP_TOP = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [CRISP_W-1:0]   in_crisp,
  input  logic                 wr_en,
  input  logic [CRISP_W-1:0]   wr_addr,
  input  logic [FZF_IDX_W-1:0] wr_index,
  input  logic [FZF_DEG_W-1:0] wr_deg_lo,
  input  logic [FZF_DEG_W-1:0] wr_deg_hi,
  output logic                 out_valid,
  output logic [FZF_IDX_W-1:0] out_index,
  output logic [FZF_DEG_W-1:0] out_deg_lo,
  output logic [FZF_DEG_W-1:0] out_deg_hi
);

  fzf_entry_t wr_word;
  fzf_entry_t raw_word;
  fzf_entry_t clean_word;
  fzf_entry_t held_word;

  always_comb begin
    wr_word.idx    = wr_index;
    wr_word.deg_lo = wr_deg_lo;
    wr_word.deg_hi = wr_deg_hi;
  end

  fzf_table #(
    .ADDR_W (CRISP_W)
  ) u_table (
    .clk      (clk),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_entry (wr_word),
    .rd_addr  (in_crisp),
    .rd_entry (raw_word)
  );

  fzf_clip #(
    .CLIP_TOP (CLIP_TOP)
  ) u_clip (
    .raw_entry   (raw_word),
    .clean_entry (clean_word)
  );

  fzf_out_reg u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (in_valid),
    .d_entry (clean_word),
    .q_valid (out_valid),
    .q_entry (held_word)
  );

  always_comb begin
    out_index  = held_word.idx;
    out_deg_lo = held_word.deg_lo;
    out_deg_hi = held_word.deg_hi;
  end

endmodule

// File: rtl/fzf_lut_fuzzifier_chk.sv
module fzf_lut_fuzzifier_chk
  import fzf_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic                 out_valid,
  input logic [FZF_IDX_W-1:0] out_index,
  input logic [FZF_DEG_W-1:0] out_deg_lo,
  input logic [FZF_DEG_W-1:0] out_deg_hi
);

  // Set once a clock edge has passed outside reset, so $past is meaningful.
  logic armed_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
    end else begin
      armed_q <= 1'b1;
    end
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_clear_R1 : assert (!out_valid && out_index == '0 &&
                                      out_deg_lo == '0 && out_deg_hi == '0);
    end
  end

  assert_valid_latency_R2 : assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |-> (out_valid == $past(in_valid)));

  assert_top_set_clip_R6 : assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_index == FZF_TOP_SET) |-> (out_deg_hi == '0));

  assert_hold_idle_R7 : assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && !$past(in_valid)) |->
      ($stable(out_index) && $stable(out_deg_lo) && $stable(out_deg_hi)));

endmodule

bind fzf_lut_fuzzifier fzf_lut_fuzzifier_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .out_valid  (out_valid),
  .out_index  (out_index),
  .out_deg_lo (out_deg_lo),
  .out_deg_hi (out_deg_hi)
);

// File: tb/fzf_lut_fuzzifier_tb_top.sv
module fzf_lut_fuzzifier_tb_top;

  localparam int CLK_PERIOD = 10;

  logic       clk;
  logic       rst_n;
  logic       in_valid;
  logic [7:0] in_crisp;
  logic       wr_en;
  logic [7:0] wr_addr;
  logic [2:0] wr_index;
  logic [7:0] wr_deg_lo;
  logic [7:0] wr_deg_hi;
  logic       out_valid;
  logic [2:0] out_index;
  logic [7:0] out_deg_lo;
  logic [7:0] out_deg_hi;

  fzf_lut_fuzzifier dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_crisp   (in_crisp),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_index   (wr_index),
    .wr_deg_lo  (wr_deg_lo),
    .wr_deg_hi  (wr_deg_hi),
    .out_valid  (out_valid),
    .out_index  (out_index),
    .out_deg_lo (out_deg_lo),
    .out_deg_hi (out_deg_hi)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic       vld;
    logic [2:0] idx;
    logic [7:0] lo;
    logic [7:0] hi;
    string      req;
  } exp_t;

  exp_t       sb_q[$];
  logic [2:0] m_idx [256];
  logic [7:0] m_lo  [256];
  logic [7:0] m_hi  [256];
  logic [2:0] last_idx;
  logic [7:0] last_lo;
  logic [7:0] last_hi;
  int         checks;
  int         fails;
  bit         done;

  task automatic check(input string req, input bit ok, input string got, input string want);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s got %s expected %s", req, got, want);
    end
  endtask

  // Driver: one cycle of stimulus, expected result pushed for the monitor.
  task automatic step(input bit lv, input logic [7:0] la, input bit we,
                      input logic [7:0] wa, input logic [2:0] wi,
                      input logic [7:0] wl, input logic [7:0] wh, input string req);
    exp_t e;
    @(negedge clk);
    in_valid = lv; in_crisp = la;
    wr_en = we; wr_addr = wa; wr_index = wi; wr_deg_lo = wl; wr_deg_hi = wh;
    if (lv) begin
      last_idx = m_idx[la];
      last_lo  = m_lo[la];
      last_hi  = (m_idx[la] == 3'd7) ? 8'd0 : m_hi[la];
    end
    e.vld = lv; e.idx = last_idx; e.lo = last_lo; e.hi = last_hi; e.req = req;
    sb_q.push_back(e);
    if (we) begin
      m_idx[wa] = wi; m_lo[wa] = wl; m_hi[wa] = wh;
    end
  endtask

  // Monitor: compares each registered result shortly after the edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        check(e.req,
              out_valid == e.vld && out_index == e.idx &&
              out_deg_lo == e.lo && out_deg_hi == e.hi,
              $sformatf("v=%0b i=%0d lo=%0d hi=%0d", out_valid, out_index, out_deg_lo, out_deg_hi),
              $sformatf("v=%0b i=%0d lo=%0d hi=%0d", e.vld, e.idx, e.lo, e.hi));
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    checks = 0; fails = 0; done = 0;
    last_idx = '0; last_lo = '0; last_hi = '0;
    rst_n = 1'b0; in_valid = 0; in_crisp = 0;
    wr_en = 0; wr_addr = 0; wr_index = 0; wr_deg_lo = 0; wr_deg_hi = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", out_valid == 0 && out_index == 0 && out_deg_lo == 0 && out_deg_hi == 0,
          $sformatf("v=%0b i=%0d lo=%0d hi=%0d", out_valid, out_index, out_deg_lo, out_deg_hi),
          "all zero");
    rst_n = 1'b1;

    // Fill the table: eight sets of 32 codes, falling/rising ramps. R4, R7
    for (int a = 0; a < 256; a++) begin
      step(0, 8'd0, 1, 8'(a), 3'(a >> 5), 8'(255 - (a % 32) * 8), 8'((a % 32) * 8), "R7");
    end

    // R3: assorted lookups, back to back
    step(1, 8'd0,   0, 0, 0, 0, 0, "R3");
    step(1, 8'd31,  0, 0, 0, 0, 0, "R3");
    step(1, 8'd32,  0, 0, 0, 0, 0, "R3");
    step(1, 8'd100, 0, 0, 0, 0, 0, "R3");
    step(1, 8'd200, 0, 0, 0, 0, 0, "R3");
    // R2, R7: gaps between requests keep the last result
    step(0, 8'd7,   0, 0, 0, 0, 0, "R2");
    step(0, 8'd9,   0, 0, 0, 0, 0, "R7");
    step(1, 8'd150, 0, 0, 0, 0, 0, "R2");
    step(0, 8'd3,   0, 0, 0, 0, 0, "R7");
    // R6: top set has a non-zero upper degree stored, must read as zero
    step(1, 8'd224, 0, 0, 0, 0, 0, "R6");
    step(1, 8'd240, 0, 0, 0, 0, 0, "R6");
    step(1, 8'd255, 0, 0, 0, 0, 0, "R6");
    step(0, 8'd0, 1, 8'd230, 3'd7, 8'd11, 8'd99, "R6");
    step(1, 8'd230, 0, 0, 0, 0, 0, "R6");
    // R4, R9: write then read it and its neighbours
    step(0, 8'd0, 1, 8'd50, 3'd5, 8'd17, 8'd200, "R4");
    step(1, 8'd50, 0, 0, 0, 0, 0, "R4");
    step(1, 8'd51, 0, 0, 0, 0, 0, "R9");
    step(1, 8'd49, 0, 0, 0, 0, 0, "R9");
    // R5: same-cycle write and lookup return the old word, next sees new
    step(1, 8'd60, 1, 8'd60, 3'd2, 8'd77, 8'd88, "R5");
    step(1, 8'd60, 0, 0, 0, 0, 0, "R4");
    // R8: data presented with write disabled changes nothing
    @(negedge clk);
    begin
      exp_t e;
      in_valid = 0; wr_en = 0; wr_addr = 8'd70; wr_index = 3'd6; wr_deg_lo = 8'd1; wr_deg_hi = 8'd2;
      e.vld = 0; e.idx = last_idx; e.lo = last_lo; e.hi = last_hi; e.req = "R8";
      sb_q.push_back(e);
    end
    step(1, 8'd70, 0, 0, 0, 0, 0, "R8");
    step(0, 8'd0, 0, 0, 0, 0, 0, "R7");
    repeat (3) @(negedge clk);

    // R1: reset in mid-run clears the output at once
    in_valid = 1; in_crisp = 8'd90;
    @(negedge clk);
    in_valid = 0;
    #1;
    sb_q.delete();
    rst_n = 1'b0;
    #1;
    check("R1", out_valid == 0 && out_index == 0 && out_deg_lo == 0 && out_deg_hi == 0,
          $sformatf("v=%0b i=%0d lo=%0d hi=%0d", out_valid, out_index, out_deg_lo, out_deg_hi),
          "all zero");
    @(negedge clk);
    rst_n = 1'b1;
    last_idx = '0; last_lo = '0; last_hi = '0;
    step(1, 8'd128, 0, 0, 0, 0, 0, "R3");
    step(0, 8'd0, 0, 0, 0, 0, 0, "R2");
    repeat (3) @(negedge clk);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule